// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block holds the local interrupt state for a small cluster of cores. Every core has seven local sources: watchdog, compare, timer, performance counter, two software interrupts and a debug channel. For each core the block keeps an enable mask, a set of routing permission flags, two software-pending bits and one routing map per source. From this state it drives that core's interrupt pins.

A single register port serves all cores. The requesting core gives its own index on every access. Address bit 4 selects one of two windows. The local window addresses the requester's own registers. The peer window addresses the registers of whichever core the requester has written into its peer-select register. This lets one core program or inspect another core's copy without any extra routing logic at the edge.

Reads are combinational from the addressed core's state. Pins and the deliverable vector follow the current state and the live hardware source levels within the same cycle.

Top module: `lirq_unit`

## Requirements
- R1: After reset, every core has mask 0, software-pending bits 0, all map registers 0, peer-select 0 and routing flags 4'b1111. With no sources active, no pin is asserted.
- R2: Source numbers are: watchdog 0, compare 1, timer 2, performance counter 3, software 0 at 4, software 1 at 5, debug 6. A write to offset 3 sets the mask bits that are 1 in wdata[6:0]. A write to offset 4 clears the mask bits that are 1 in wdata[6:0]. Zero bits leave the mask unchanged. Offset 2 reads the mask in bits [6:0].
- R3: For each core, the deliverable vector is the pending vector ANDed with the mask.
- R4: Offset 0 holds the routing flags, read and written in bits [3:0]. Bit 0 permits the timer, bit 1 the performance counter, bit 2 the debug channel, and bit 3 both software sources. Watchdog and compare are always routable.
- R5: Address bit 4 = 0 targets the requesting core. Bit 4 = 1 targets the core named in the requester's peer-select register (offset 5, low 2 bits). Peer-select is reachable only through the local window. Through the peer window it reads 0 and writes to it are ignored.
- R6: Offsets 8 to 14 are the map registers for sources 0 to 6. Bit 31 is the map enable and bits [2:0] are the target pin. Only these bits are stored and read back.
- R7: Pin p of a core is 1 exactly when some source is deliverable, routable and map-enabled, and its map pin equals p. Pin values of 6 or 7 drive no pin.
- R8: A write to offset 6 sets software pending bit 0 or 1 when wdata bit 4 or 5 is 1. A write to offset 7 clears them the same way. The hardware source inputs at positions 4 and 5 are ignored.
- R9: Offset 1 reads the pending vector: live hardware levels at bits 0-3 and 6, software bits at 4-5, and zero above. Offsets 3, 4, 6, 7 and 15 read 0. A write to offset 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_core | input | 2 | Index of the core making the access |
| req_wr | input | 1 | Write strobe |
| req_addr | input | 5 | Bit 4 selects the window, bits [3:0] the offset |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data for the addressed register |
| hw_src | input | 28 | Source levels, 7 per core, core c at [7c+6:7c] |
| core_pins | output | 24 | Interrupt pins, 6 per core, core c at [6c+5:6c] |
| core_dlv | output | 28 | Deliverable vectors, 7 per core |

## Verification
The bench targets four failure modes:
- Peer-window aliasing. Writes through another core's window must land only on the selected core, and the peer-select register must stay out of reach from that window. A wrong decode would corrupt the requester's own state or let the peer-select register be rewritten through the peer window.
- Routing gates. Clearing the shared software flag must silence both software sources but leave the watchdog and compare paths intact. A decoder using the wrong flag bit would keep a blocked source alive on a pin.
- Out-of-range pins. Map pins of 6 and 7 must drive nothing; a design without the range check would wrap the value onto a real pin.
- Write-1 semantics and input masking. Zero bits in set and clear writes must not disturb the mask, and the hardware inputs at the software positions must not leak into the pending vector.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int NSRC = 7;
    localparam int SRC_WD   = 0;
    localparam int SRC_CMP  = 1;
    localparam int SRC_TMR  = 2;
    localparam int SRC_PERF = 3;
    localparam int SRC_SW0  = 4;
    localparam int SRC_SW1  = 5;
    localparam int SRC_DBG  = 6;

    localparam logic [3:0] OFF_ROUTE  = 4'd0;
    localparam logic [3:0] OFF_PEND   = 4'd1;
    localparam logic [3:0] OFF_MASK   = 4'd2;
    localparam logic [3:0] OFF_EN_SET = 4'd3;
    localparam logic [3:0] OFF_EN_CLR = 4'd4;
    localparam logic [3:0] OFF_PEER   = 4'd5;
    localparam logic [3:0] OFF_SW_SET = 4'd6;
    localparam logic [3:0] OFF_SW_CLR = 4'd7;
    localparam logic [3:0] OFF_MAP0   = 4'd8;
endpackage

// File: rtl/lirq_core_regs.sv
module lirq_core_regs
    import lirq_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 3,
    parameter int CW = 2,
    parameter logic [3:0] ROUTE_RST = 4'hF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_off,
    input  logic [DW-1:0]        wr_data,
    input  logic [NSRC-1:0]      hw_lvl,
    input  logic [3:0]           rd_off,
    output logic [DW-1:0]        rd_data,
    output logic [NSRC-1:0]      dlv,
    output logic [NSRC-1:0]      routable,
    output logic [NSRC-1:0]      map_en,
    output logic [NSRC*PW-1:0]   map_pin,
    output logic [CW-1:0]        peer
);
    typedef struct packed {
        logic [3:0]         route;
        logic [NSRC-1:0]    mask;
        logic [1:0]         swp;
        logic [CW-1:0]      peer;
        logic [NSRC-1:0]    men;
        logic [NSRC*PW-1:0] mpin;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] pend;

    always_comb begin
        pend = hw_lvl;
        pend[SRC_SW0] = st_q.swp[0];
        pend[SRC_SW1] = st_q.swp[1];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_off)
                OFF_ROUTE:  st_d.route = wr_data[3:0];
                OFF_EN_SET: st_d.mask  = st_q.mask | wr_data[NSRC-1:0];
                OFF_EN_CLR: st_d.mask  = st_q.mask & ~wr_data[NSRC-1:0];
                OFF_PEER:   st_d.peer  = wr_data[CW-1:0];
                OFF_SW_SET: st_d.swp   = st_q.swp | wr_data[SRC_SW1:SRC_SW0];
                OFF_SW_CLR: st_d.swp   = st_q.swp & ~wr_data[SRC_SW1:SRC_SW0];
                default: begin
                    for (int s = 0; s < NSRC; s++) begin
                        if (wr_off == OFF_MAP0 + 4'(s)) begin
                            st_d.men[s]           = wr_data[DW-1];
                            st_d.mpin[s*PW +: PW] = wr_data[PW-1:0];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{route: ROUTE_RST, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_off)
            OFF_ROUTE: rd_data[3:0]      = st_q.route;
            OFF_PEND:  rd_data[NSRC-1:0] = pend;
            OFF_MASK:  rd_data[NSRC-1:0] = st_q.mask;
            OFF_PEER:  rd_data[CW-1:0]   = st_q.peer;
            default: begin
                for (int s = 0; s < NSRC; s++) begin
                    if (rd_off == OFF_MAP0 + 4'(s)) begin
                        rd_data[DW-1]   = st_q.men[s];
                        rd_data[PW-1:0] = st_q.mpin[s*PW +: PW];
                    end
                end
            end
        endcase
    end

    assign dlv      = pend & st_q.mask;
    assign routable = {st_q.route[2], st_q.route[3], st_q.route[3],
                       st_q.route[1], st_q.route[0], 1'b1, 1'b1};
    assign map_en   = st_q.men;
    assign map_pin  = st_q.mpin;
    assign peer     = st_q.peer;

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_EN_SET) |=>
        ((st_q.mask & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));
    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_EN_CLR) |=>
        ((st_q.mask & $past(wr_data[NSRC-1:0])) == '0));
    // R8
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_SW_SET && wr_data[SRC_SW0]) |=> st_q.swp[0]);
    // R5
    peer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.peer));
endmodule

// File: rtl/lirq_pin_route.sv
module lirq_pin_route
    import lirq_pkg::*;
#(
    parameter int NPINS = 6,
    parameter int PW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     dlv,
    input  logic [NSRC-1:0]     routable,
    input  logic [NSRC-1:0]     map_en,
    input  logic [NSRC*PW-1:0]  map_pin,
    output logic [NPINS-1:0]    pins
);
    logic [NSRC-1:0] live;
    assign live = dlv & routable & map_en;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_comb begin
            pins[p] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (live[s] && map_pin[s*PW +: PW] == PW'(p)) pins[p] = 1'b1;
            end
        end
    end

    // R7
    pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pins) |-> (|(dlv & routable & map_en)));
    // R4
    blocked_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!routable[SRC_TMR] && live == '0) |-> (pins == '0));
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
    import lirq_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NPINS  = 6,
    parameter int DW     = 32,
    localparam int CW    = $clog2(NCORES),
    localparam int PW    = $clog2(NPINS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           req_core,
    input  logic                    req_wr,
    input  logic [4:0]              req_addr,
    input  logic [DW-1:0]           req_wdata,
    output logic [DW-1:0]           req_rdata,
    input  logic [NCORES*NSRC-1:0]  hw_src,
    output logic [NCORES*NPINS-1:0] core_pins,
    output logic [NCORES*NSRC-1:0]  core_dlv
);
    logic [DW-1:0] rd_all [NCORES];
    logic [CW-1:0] peer_all [NCORES];
    logic          win_peer;
    logic [3:0]    off;
    logic [CW-1:0] tgt;
    logic          peer_reg_blk;

    assign win_peer     = req_addr[4];
    assign off          = req_addr[3:0];
    assign tgt          = win_peer ? peer_all[req_core] : req_core;
    assign peer_reg_blk = win_peer && (off == OFF_PEER);

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic [NSRC-1:0]    dlv, rout, men;
        logic [NSRC*PW-1:0] mpin;
        logic               wr_here;

        assign wr_here = req_wr && (tgt == CW'(c)) && !peer_reg_blk;

        lirq_core_regs #(.DW(DW), .PW(PW), .CW(CW)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_here),
            .wr_off   (off),
            .wr_data  (req_wdata),
            .hw_lvl   (hw_src[c*NSRC +: NSRC]),
            .rd_off   (off),
            .rd_data  (rd_all[c]),
            .dlv      (dlv),
            .routable (rout),
            .map_en   (men),
            .map_pin  (mpin),
            .peer     (peer_all[c])
        );

        lirq_pin_route #(.NPINS(NPINS), .PW(PW)) u_route (
            .clk      (clk),
            .rst_n    (rst_n),
            .dlv      (dlv),
            .routable (rout),
            .map_en   (men),
            .map_pin  (mpin),
            .pins     (core_pins[c*NPINS +: NPINS])
        );

        assign core_dlv[c*NSRC +: NSRC] = dlv;
    end

    assign req_rdata = peer_reg_blk ? '0 : rd_all[tgt];

    // R5
    peer_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_peer && off == OFF_PEER) |-> (req_rdata == '0));
endmodule

// File: tb/sim_lirq_unit.sv
module sim_lirq_unit;
    localparam int NC = 4;
    localparam int NS = 7;
    localparam int NP = 6;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [1:0]    req_core = 0;
    logic          req_wr = 0;
    logic [4:0]    req_addr = 0;
    logic [31:0]   req_wdata = 0;
    logic [31:0]   req_rdata;
    logic [NC*NS-1:0] hw_src = 0;
    logic [NC*NP-1:0] core_pins;
    logic [NC*NS-1:0] core_dlv;

    lirq_unit u0 (.*);

    always #2 clk = ~clk;

    int nvec = 0, nbad = 0, cyc = 0;

    logic [3:0] m_route [NC];
    logic [6:0] m_mask  [NC];
    logic [1:0] m_sw    [NC];
    logic [1:0] m_peer  [NC];
    logic [6:0] m_men   [NC];
    logic [2:0] m_pin   [NC][NS];

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nbad++;
            $display("FAIL watchdog: actual %0d cycles, expected < 100000", cyc);
            finish_run();
        end
    end

    function automatic logic [6:0] m_pend(int c);
        logic [6:0] p = hw_src[c*NS +: NS];
        p[5:4] = m_sw[c];
        return p;
    endfunction

    function automatic bit m_rout(int c, int s);
        case (s)
            0, 1: return 1'b1;
            2: return m_route[c][0];
            3: return m_route[c][1];
            4, 5: return m_route[c][3];
            default: return m_route[c][2];
        endcase
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [1:0] tgt;
        logic [3:0] off;
        logic [31:0] er;
        string tag;
        off = req_addr[3:0];
        tgt = req_addr[4] ? m_peer[req_core] : req_core;
        er = 0;
        tag = "R9 rdata";
        case (off)
            0: begin er[3:0] = m_route[tgt]; tag = "R4 route rdata"; end
            1: begin er[6:0] = m_pend(tgt); tag = "R9 R8 pend rdata"; end
            2: begin er[6:0] = m_mask[tgt]; tag = "R2 mask rdata"; end
            5: begin
                if (!req_addr[4]) er[1:0] = m_peer[req_core];
                tag = "R5 peer rdata";
            end
            8, 9, 10, 11, 12, 13, 14: begin
                er[31] = m_men[tgt][off-8];
                er[2:0] = m_pin[tgt][off-8];
                tag = "R6 map rdata";
            end
            default: ;
        endcase
        cmp(tag, req_rdata, er);
        for (int c = 0; c < NC; c++) begin
            logic [6:0] d = m_pend(c) & m_mask[c];
            logic [5:0] pe = 0;
            cmp("R3 dlv", 32'(core_dlv[c*NS +: NS]), 32'(d));
            for (int s = 0; s < NS; s++)
                if (d[s] && m_rout(c, s) && m_men[c][s] && m_pin[c][s] < NP)
                    pe[m_pin[c][s]] = 1'b1;
            cmp("R7 R4 pins", 32'(core_pins[c*NP +: NP]), 32'(pe));
        end
    endtask

    task automatic model_write();
        logic [1:0] tgt;
        int off;
        off = int'(req_addr[3:0]);
        tgt = req_addr[4] ? m_peer[req_core] : req_core;
        case (off)
            0: m_route[tgt] = req_wdata[3:0];
            3: m_mask[tgt] = m_mask[tgt] | req_wdata[6:0];
            4: m_mask[tgt] = m_mask[tgt] & ~req_wdata[6:0];
            5: if (!req_addr[4]) m_peer[req_core] = req_wdata[1:0];
            6: m_sw[tgt] = m_sw[tgt] | req_wdata[5:4];
            7: m_sw[tgt] = m_sw[tgt] & ~req_wdata[5:4];
            8, 9, 10, 11, 12, 13, 14: begin
                m_men[tgt][off-8] = req_wdata[31];
                m_pin[tgt][off-8] = req_wdata[2:0];
            end
            default: ;
        endcase
    endtask

    task automatic step(bit wr, int core, logic [4:0] addr, logic [31:0] wd);
        @(negedge clk);
        req_wr = wr;
        req_core = 2'(core);
        req_addr = addr;
        req_wdata = wd;
        #1;
        check_all();
        if (wr) model_write();
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_route[c] = 4'hF; m_mask[c] = 0; m_sw[c] = 0;
            m_peer[c] = 0; m_men[c] = 0;
            for (int s = 0; s < NS; s++) m_pin[c][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state read through every offset of core 0 and core 2
        for (int o = 0; o < 16; o++) step(0, 0, 5'(o), 0);
        for (int o = 0; o < 16; o++) step(0, 2, 5'(o), 0);
        // R2: set then clear mask bits, zero bits untouched
        hw_src = {NC*NS{1'b1}};
        step(1, 0, 5'd3, 32'h0000_0055);
        step(0, 0, 5'd2, 0);
        step(1, 0, 5'd4, 32'h0000_0011);
        step(0, 0, 5'd2, 0);
        // R6 R7: map watchdog to pin 2, compare to pin 7 (out of range)
        step(1, 0, 5'd8, 32'h8000_0002);
        step(1, 0, 5'd3, 32'h0000_0003);
        step(1, 0, 5'd9, 32'h8000_0007);
        step(0, 0, 5'd9, 0);
        // R8: hw bits 4/5 ignored, software set/clear
        step(0, 1, 5'd1, 0);
        step(1, 1, 5'd6, 32'h0000_0020);
        step(0, 1, 5'd1, 0);
        step(1, 1, 5'd3, 32'h0000_0030);
        step(1, 1, 5'd13, 32'h8000_0004);
        // R4: clearing software flag removes pin, watchdog stays
        step(1, 1, 5'd8, 32'h8000_0004);
        step(1, 1, 5'd3, 32'h0000_0001);
        step(1, 1, 5'd0, 32'h0000_0007);
        step(0, 1, 5'd0, 0);
        step(1, 1, 5'd7, 32'h0000_0020);
        // R5: peer window writes to core 3, peer-select blocked from peer window
        step(1, 0, 5'd5, 32'h0000_0003);
        step(1, 0, 5'h13, 32'h0000_007F);
        step(1, 0, 5'h15, 32'h0000_0001);
        step(0, 0, 5'h15, 0);
        step(0, 0, 5'd5, 0);
        step(0, 3, 5'd2, 0);
        step(0, 0, 5'h12, 0);
        // R9: offset 15 write has no effect
        step(1, 2, 5'd15, 32'hFFFF_FFFF);
        step(0, 2, 5'd0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 16 == 0) hw_src = NC*NS'($urandom);
            step($urandom_range(0, 2) != 0, $urandom_range(0, 3),
                 5'($urandom), ($urandom_range(0, 1) ? 32'h8000_0000 : 0) | 32'($urandom_range(0, 255)));
        end
        finish_run();
    end
endmodule